// File: doc/BRIEF.md
# Calendar Control Register Bank

This block is the host-facing register file of a link-layer flow-control status generator. A host reaches it through a 4-bit word address, a 16-bit data path and separate read and write strobes. It holds the generator's control bits and two sets of calendar parameters. Each set has a length and a repetition count. The block also holds two calendar memories of 8-bit entries. The host reaches these memories indirectly through one shared address register and two data windows.

The generator keeps using one calendar while the host rewrites the other. It reports two things back to the bank: which calendar is in use, and whether it is disabled. The bank uses these to refuse writes to the calendar set that the generator is currently using. When hitless switching is off, the second calendar set is hidden. The generator reads the memory entries through its own read port on each memory. Host reads are registered, so a result appears one cycle after the read strobe. This matches the one-cycle latency of the synchronous memories.

Top module: `cal_regbank`

## Requirements
- R1: A read of word 0 returns the 3-bit block identifier in bits 15:13 and the 13-bit identification code in bits 12:0. The defaults are 3'd5 and 13'h0A5C, so the word reads 16'hAA5C.
- R2: After reset the force-framing bit is 1. The hitless enable, the calendar request, both repetition counts, both lengths and the memory address register are all 0.
- R3: Word 1 layout:
  - bit 0: hitless enable, read/write.
  - bit 1: force framing, read/write.
  - bit 2: requested calendar, read/write.
  - bit 3: the `cal_active` input, read-only.
  - bit 5: the `gen_disabled` input, read-only.
  - All other bits read 0. Writes to the read-only bits and the other bits have no effect.
- R4: Word 2 is the 8-bit repetition count of calendar 0 and word 3 that of calendar 1. Word 4 is the 10-bit length of calendar 0 and word 5 that of calendar 1. Unused upper bits read 0. The stored values drive `rep0`, `rep1`, `len0` and `len1`.
- R5: Word 6 is the 10-bit memory address register. A write to word 7 stores data bits 7:0 into memory 0 at that address, and a read of word 7 returns that entry in bits 7:0. Word 8 does the same for memory 1.
- R6: Writes to words 2, 4 and 7 take effect only when `gen_disabled` is 1 or `cal_active` is 1. Otherwise they are dropped and the stored value is unchanged.
- R7: Writes to words 3, 5 and 8 take effect only when `gen_disabled` is 1 or `cal_active` is 0. Otherwise they are dropped.
- R8: While the hitless enable is 0, words 3, 5 and 8 read 0 and writes to them are dropped.
- R9: Words 9 to 15 read 0, and writes to them change no register and no memory entry.
- R10: `rdata` takes its new value on the clock edge that samples `rd_en`, so it is valid one cycle after the strobe. It then holds that value until the next read.
- R11: `gen_data0` and `gen_data1` show the memory 0 and memory 1 entries addressed by `gen_addr0` and `gen_addr1` one cycle earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 4 | Word address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Registered read data |
| gen_disabled | input | 1 | Generator disabled status |
| cal_active | input | 1 | Calendar currently in use by the generator |
| gen_addr0 | input | 10 | Generator read address, memory 0 |
| gen_addr1 | input | 10 | Generator read address, memory 1 |
| gen_data0 | output | 8 | Generator read data, memory 0 |
| gen_data1 | output | 8 | Generator read data, memory 1 |
| hitless_en | output | 1 | Hitless calendar switching enable |
| force_frame | output | 1 | Force continuous framing word |
| cal_req | output | 1 | Requested calendar select |
| rep0 | output | 8 | Repetition count, calendar 0 |
| rep1 | output | 8 | Repetition count, calendar 1 |
| len0 | output | 10 | Length, calendar 0 |
| len1 | output | 10 | Length, calendar 1 |

## Verification
The assertions assume that `gen_disabled` and `cal_active` are stable across the edge that samples a write. The protection checks compare the stored value one cycle later against the status seen at that edge. The bench changes these inputs only at falling edges, between operations. It also applies at most one strobe per cycle. Memory addresses come from a small pool that is fully written at the start of the run. This means no read, by the host or by the generator port, ever returns an entry that was never written.

// File: rtl/cal_regbank_pkg.sv
package cal_regbank_pkg;
    localparam int DATA_W  = 16;
    localparam int WADDR_W = 4;
    localparam int CAL_AW  = 10;
    localparam int ENT_W   = 8;
    localparam int REP_W   = 8;
    localparam int LEN_W   = 10;
    localparam int IDC_W   = 13;
    localparam int BLK_W   = 3;
    localparam int NUM_CAL = 2;

    typedef enum logic [1:0] {
        RS_REG  = 2'd0,
        RS_MEM0 = 2'd1,
        RS_MEM1 = 2'd2
    } rsel_e;

    typedef struct packed {
        logic              hen;
        logic              force_fr;
        logic              req;
        logic [REP_W-1:0]  rep0;
        logic [REP_W-1:0]  rep1;
        logic [LEN_W-1:0]  len0;
        logic [LEN_W-1:0]  len1;
        logic [CAL_AW-1:0] maddr;
        logic [DATA_W-1:0] rdreg;
        rsel_e             rsel;
    } bank_t;
endpackage

// File: rtl/cal_ram.sv
module cal_ram #(
    parameter int AW = 10,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          hre,
    input  logic [AW-1:0] haddr,
    output logic [DW-1:0] hdata,
    input  logic [AW-1:0] gaddr,
    output logic [DW-1:0] gdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
        if (hre) begin
            hdata <= mem[haddr];
        end
        gdata <= mem[gaddr];
    end
endmodule

// File: rtl/cal_wr_guard.sv
module cal_wr_guard (
    input  logic gen_disabled,
    input  logic cal_active,
    input  logic hitless_en,
    output logic ok0,
    output logic ok1
);
    // A set is writable only while the generator is not using it.
    always_comb begin
        ok0 = gen_disabled | cal_active;
        ok1 = hitless_en & (gen_disabled | ~cal_active);
    end
endmodule

// File: rtl/cal_regbank.sv
module cal_regbank
    import cal_regbank_pkg::*;
#(
    parameter logic [IDC_W-1:0] ID_CODE  = 13'h0A5C,
    parameter logic [BLK_W-1:0] BLOCK_ID = 3'd5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic                rd_en,
    input  logic [WADDR_W-1:0]  addr,
    input  logic [DATA_W-1:0]   wdata,
    output logic [DATA_W-1:0]   rdata,
    input  logic                gen_disabled,
    input  logic                cal_active,
    input  logic [CAL_AW-1:0]   gen_addr0,
    input  logic [CAL_AW-1:0]   gen_addr1,
    output logic [ENT_W-1:0]    gen_data0,
    output logic [ENT_W-1:0]    gen_data1,
    output logic                hitless_en,
    output logic                force_frame,
    output logic                cal_req,
    output logic [REP_W-1:0]    rep0,
    output logic [REP_W-1:0]    rep1,
    output logic [LEN_W-1:0]    len0,
    output logic [LEN_W-1:0]    len1
);
    localparam logic [WADDR_W-1:0] W_ID    = 4'd0;
    localparam logic [WADDR_W-1:0] W_CTL   = 4'd1;
    localparam logic [WADDR_W-1:0] W_REP0  = 4'd2;
    localparam logic [WADDR_W-1:0] W_REP1  = 4'd3;
    localparam logic [WADDR_W-1:0] W_LEN0  = 4'd4;
    localparam logic [WADDR_W-1:0] W_LEN1  = 4'd5;
    localparam logic [WADDR_W-1:0] W_MADDR = 4'd6;
    localparam logic [WADDR_W-1:0] W_MEM0  = 4'd7;
    localparam logic [WADDR_W-1:0] W_MEM1  = 4'd8;
    localparam logic [WADDR_W-1:0] W_LAST  = 4'd8;
    localparam logic [DATA_W-1:0]  ID_WORD = {BLOCK_ID, ID_CODE};
    localparam int PAD_REP = DATA_W - REP_W;
    localparam int PAD_LEN = DATA_W - LEN_W;
    localparam int PAD_ADR = DATA_W - CAL_AW;
    localparam int PAD_ENT = DATA_W - ENT_W;

    localparam bank_t RST_VAL = '{
        hen: 1'b0, force_fr: 1'b1, req: 1'b0,
        rep0: '0, rep1: '0, len0: '0, len1: '0,
        maddr: '0, rdreg: '0, rsel: RS_REG
    };

    bank_t st_q, st_d;
    logic  ok0, ok1;
    logic [NUM_CAL-1:0] mem_we_d, mem_re_d;
    logic [ENT_W-1:0]   hdata [NUM_CAL];
    logic [CAL_AW-1:0]  gaddr [NUM_CAL];
    logic [ENT_W-1:0]   gdata [NUM_CAL];

    cal_wr_guard u_guard (
        .gen_disabled (gen_disabled),
        .cal_active   (cal_active),
        .hitless_en   (st_q.hen),
        .ok0          (ok0),
        .ok1          (ok1)
    );

    assign gaddr[0] = gen_addr0;
    assign gaddr[1] = gen_addr1;

    for (genvar k = 0; k < NUM_CAL; k++) begin : g_mem
        cal_ram #(.AW(CAL_AW), .DW(ENT_W)) u_ram (
            .clk   (clk),
            .we    (mem_we_d[k]),
            .waddr (st_q.maddr),
            .wdata (wdata[ENT_W-1:0]),
            .hre   (mem_re_d[k]),
            .haddr (st_q.maddr),
            .hdata (hdata[k]),
            .gaddr (gaddr[k]),
            .gdata (gdata[k])
        );
    end

    always_comb begin
        st_d     = st_q;
        mem_we_d = '0;
        mem_re_d = '0;
        if (wr_en) begin
            unique case (addr)
                W_CTL: begin
                    st_d.hen      = wdata[0];
                    st_d.force_fr = wdata[1];
                    st_d.req      = wdata[2];
                end
                W_REP0:  if (ok0) st_d.rep0 = wdata[REP_W-1:0];
                W_REP1:  if (ok1) st_d.rep1 = wdata[REP_W-1:0];
                W_LEN0:  if (ok0) st_d.len0 = wdata[LEN_W-1:0];
                W_LEN1:  if (ok1) st_d.len1 = wdata[LEN_W-1:0];
                W_MADDR: st_d.maddr = wdata[CAL_AW-1:0];
                W_MEM0:  mem_we_d[0] = ok0;
                W_MEM1:  mem_we_d[1] = ok1;
                default: ;
            endcase
        end
        if (rd_en) begin
            st_d.rsel  = RS_REG;
            st_d.rdreg = '0;
            unique case (addr)
                W_ID:    st_d.rdreg = ID_WORD;
                W_CTL:   st_d.rdreg = {10'd0, gen_disabled, 1'b0, cal_active,
                                       st_q.req, st_q.force_fr, st_q.hen};
                W_REP0:  st_d.rdreg = {{PAD_REP{1'b0}}, st_q.rep0};
                W_REP1:  if (st_q.hen) st_d.rdreg = {{PAD_REP{1'b0}}, st_q.rep1};
                W_LEN0:  st_d.rdreg = {{PAD_LEN{1'b0}}, st_q.len0};
                W_LEN1:  if (st_q.hen) st_d.rdreg = {{PAD_LEN{1'b0}}, st_q.len1};
                W_MADDR: st_d.rdreg = {{PAD_ADR{1'b0}}, st_q.maddr};
                W_MEM0: begin
                    st_d.rsel   = RS_MEM0;
                    mem_re_d[0] = 1'b1;
                end
                W_MEM1: if (st_q.hen) begin
                    st_d.rsel   = RS_MEM1;
                    mem_re_d[1] = 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= RST_VAL;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        unique case (st_q.rsel)
            RS_MEM0: rdata = {{PAD_ENT{1'b0}}, hdata[0]};
            RS_MEM1: rdata = {{PAD_ENT{1'b0}}, hdata[1]};
            default: rdata = st_q.rdreg;
        endcase
    end

    assign gen_data0   = gdata[0];
    assign gen_data1   = gdata[1];
    assign hitless_en  = st_q.hen;
    assign force_frame = st_q.force_fr;
    assign cal_req     = st_q.req;
    assign rep0        = st_q.rep0;
    assign rep1        = st_q.rep1;
    assign len0        = st_q.len0;
    assign len1        = st_q.len1;

    AST_ID_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == W_ID) |=> (rdata == ID_WORD)); // R1
    AST_CAL0_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (addr == W_REP0 || addr == W_LEN0) && !gen_disabled && !cal_active)
        |=> ($stable(rep0) && $stable(len0))); // R6
    AST_CAL1_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (addr == W_REP1 || addr == W_LEN1) && !gen_disabled && cal_active)
        |=> ($stable(rep1) && $stable(len1))); // R7
    AST_CAL1_HIDDEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!hitless_en && wr_en && (addr == W_REP1 || addr == W_LEN1))
        |=> ($stable(rep1) && $stable(len1))); // R8
    AST_RSVD_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr > W_LAST) |=> (rdata == '0)); // R9
    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata)); // R10
endmodule

// File: tb/cal_regbank_test.sv
module cal_regbank_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [3:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        gen_disabled = 1'b0, cal_active = 1'b0;
    logic [9:0]  gen_addr0 = '0, gen_addr1 = '0;
    logic [7:0]  gen_data0, gen_data1;
    logic        hitless_en, force_frame, cal_req;
    logic [7:0]  rep0, rep1;
    logic [9:0]  len0, len1;

    int checks = 0, errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    cal_regbank uut (.*);

    // bench model
    bit         m_hen, m_force, m_req;
    logic [7:0] m_rep0, m_rep1;
    logic [9:0] m_len0, m_len1, m_maddr;
    logic [7:0] m_mem0 [1024];
    logic [7:0] m_mem1 [1024];

    function automatic logic [9:0] pool(int k);
        return 10'((k * 131) % 1024);
    endfunction

    function automatic bit okw0();
        return gen_disabled || cal_active;
    endfunction

    function automatic bit okw1();
        return m_hen && (gen_disabled || !cal_active);
    endfunction

    function automatic logic [15:0] exp_read(logic [3:0] a);
        case (a)
            4'd0: return 16'hAA5C;
            4'd1: return {10'd0, gen_disabled, 1'b0, cal_active, m_req, m_force, m_hen};
            4'd2: return {8'd0, m_rep0};
            4'd3: return m_hen ? {8'd0, m_rep1} : 16'd0;
            4'd4: return {6'd0, m_len0};
            4'd5: return m_hen ? {6'd0, m_len1} : 16'd0;
            4'd6: return {6'd0, m_maddr};
            4'd7: return {8'd0, m_mem0[m_maddr]};
            4'd8: return m_hen ? {8'd0, m_mem1[m_maddr]} : 16'd0;
            default: return 16'd0;
        endcase
    endfunction

    function automatic string tag_of(logic [3:0] a);
        case (a)
            4'd0: return "R1";
            4'd1: return "R3";
            4'd2, 4'd4: return "R4";
            4'd3, 4'd5: return "R8";
            4'd6, 4'd7: return "R5";
            4'd8: return "R8";
            default: return "R9";
        endcase
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_write(logic [3:0] a, logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        case (a)
            4'd1: begin m_hen = d[0]; m_force = d[1]; m_req = d[2]; end
            4'd2: if (okw0()) m_rep0 = d[7:0];
            4'd3: if (okw1()) m_rep1 = d[7:0];
            4'd4: if (okw0()) m_len0 = d[9:0];
            4'd5: if (okw1()) m_len1 = d[9:0];
            4'd6: m_maddr = d[9:0];
            4'd7: if (okw0()) m_mem0[m_maddr] = d[7:0];
            4'd8: if (okw1()) m_mem1[m_maddr] = d[7:0];
            default: ;
        endcase
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_read(logic [3:0] a, string req);
        logic [15:0] e;
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        e = exp_read(a);
        @(negedge clk);
        rd_en = 1'b0;
        check(req, 32'(rdata), 32'(e));
    endtask

    task automatic check_outputs(string req);
        check(req, {29'd0, hitless_en, force_frame, cal_req}, {29'd0, m_hen, m_force, m_req});
        check(req, {rep1, rep0, 16'd0}, {m_rep1, m_rep0, 16'd0});
        check(req, {12'd0, len1, len0}, {12'd0, m_len1, m_len0});
    endtask

    task automatic check_gen(int k0, int k1);
        @(negedge clk);
        gen_addr0 = pool(k0); gen_addr1 = pool(k1);
        @(negedge clk);
        check("R11", {16'd0, gen_data1, gen_data0},
              {16'd0, m_mem1[pool(k1)], m_mem0[pool(k0)]});
    endtask

    initial begin
        void'($urandom(32'h5EED_1234));
        m_hen = 0; m_force = 1; m_req = 0;
        m_rep0 = 0; m_rep1 = 0; m_len0 = 0; m_len1 = 0; m_maddr = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R2 reset state
        check_outputs("R2");
        do_read(4'd1, "R2");
        do_read(4'd6, "R2");
        do_read(4'd0, "R1");

        // R10 read data held with no strobe
        repeat (3) @(negedge clk);
        check("R10", 32'(rdata), 32'h0000AA5C);

        // R3 read-only bits ignore writes
        gen_disabled = 1'b1;
        do_write(4'd1, 16'hFFFF);
        do_read(4'd1, "R3");
        check_outputs("R3");

        // fill memory pool (disabled generator, hitless on)
        for (int k = 0; k < 8; k++) begin
            do_write(4'd6, {6'd0, pool(k)});
            do_write(4'd7, 16'(8'h10 + k));
            do_write(4'd8, 16'(8'hA0 + k));
        end
        for (int k = 0; k < 8; k++) begin
            do_write(4'd6, {6'd0, pool(k)});
            do_read(4'd7, "R5");
            do_read(4'd8, "R5");
        end
        check_gen(3, 5);

        // R6: calendar 0 locked while in use
        gen_disabled = 1'b0; cal_active = 1'b0;
        do_write(4'd2, 16'h00C3);
        do_write(4'd4, 16'h03FF);
        check_outputs("R6");
        do_read(4'd2, "R6");
        do_read(4'd7, "R6");
        do_write(4'd7, 16'h005A);
        do_read(4'd7, "R6");
        cal_active = 1'b1;
        do_write(4'd2, 16'hFFC3);
        do_read(4'd2, "R6");

        // R7: calendar 1 locked while in use
        do_write(4'd3, 16'h0077);
        do_write(4'd8, 16'h0066);
        do_read(4'd3, "R7");
        do_read(4'd8, "R7");
        cal_active = 1'b0;
        do_write(4'd5, 16'h0155);
        do_read(4'd5, "R7");

        // R8: calendar 1 hidden when hitless off
        gen_disabled = 1'b1;
        do_write(4'd1, 16'h0002);
        do_write(4'd3, 16'h0011);
        do_write(4'd8, 16'h0022);
        do_read(4'd3, "R8");
        do_read(4'd8, "R8");
        check_outputs("R8");

        // R9: reserved words
        do_write(4'd12, 16'hFFFF);
        do_read(4'd12, "R9");
        do_read(4'd15, "R9");
        check_outputs("R9");
        do_write(4'd1, 16'h0001);
        do_read(4'd3, "R9");

        // constrained random
        for (int i = 0; i < 3000; i++) begin
            logic [3:0]  a;
            logic [15:0] d;
            @(negedge clk);
            if ($urandom_range(3) == 0) gen_disabled = ~gen_disabled;
            if ($urandom_range(3) == 0) cal_active = ~cal_active;
            a = 4'($urandom_range(15));
            d = 16'($urandom);
            if (a == 4'd6) d[9:0] = pool($urandom_range(7));
            if ($urandom_range(1) == 0) do_write(a, d);
            else do_read(a, tag_of(a));
            if ($urandom_range(15) == 0) check_gen($urandom_range(7), $urandom_range(7));
        end
        check_outputs("R4");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule